// File: doc/BRIEF.md
# Bridge Configuration Register Controller

This block holds the registers of a type-1 configuration header that belong to a bridge. These are the bus numbers, the I/O, memory and prefetchable window base and limit fields with their upper extensions, the bridge control word, and the command word that gates forwarding. Configuration software writes dwords through a byte-enabled port and reads them back on a combinational read port. The window fields are also presented already expanded into full base and limit addresses, so a downstream address decoder can compare against them directly.

Some writes change the forwarding windows: writes that touch the command word, the I/O base/limit byte pair, or any byte from 0x20 through 0x33. The block answers each of these with a one-cycle remap-update pulse, so the decoder can swap all of its windows in a single step. Setting the secondary-bus-reset bit of bridge control from 0 to 1 produces a one-cycle reset pulse toward the secondary side. At reset, a mode input chooses how the windows start. They start either zeroed, or closed, with every base above its limit.

Top module: `bridge_cfg_ctrl`

## Requirements
- R1: The cycle after a write strobe, `remap_pulse_o` is high for exactly one cycle if some enabled byte lies at byte offset 0x04, 0x05, 0x1C, 0x1D or anywhere in 0x20..0x33. It is low after any other write.
- R2: `sec_bus_reset_o` pulses for one cycle, the cycle after a write strobe, only when that write (byte lane 2 enabled, dword 0x3C) changes bridge-control bit 6 (bit 22 of that dword) from 0 to 1. Rewriting a 1, clearing, or writing with lane 2 disabled gives no pulse.
- R3: Reset clears the dword at 0x18, which holds the primary, secondary and subordinate bus numbers and the secondary latency timer.
- R4: When reset is applied with `closed_on_reset` low, the following fields read zero afterwards:
  - the writable window fields (I/O base/limit bits 7:4; memory and prefetchable base/limit bits 15:4);
  - the upper prefetchable dwords at 0x28 and 0x2C;
  - the I/O upper halves at 0x30;
  - bridge control.
- R5: When reset is applied with `closed_on_reset` high, the writable base fields become all ones and the limit fields zero. As a result `io_base_o`=0x0000F000, `io_limit_o`=0x00000FFF, `mem_base_o`=0xFFF00000, `mem_limit_o`=0x000FFFFF, `pref_base_o`=0xFFF00000 and `pref_limit_o`=0x000FFFFF.
- R6: The primary status half-word (0x06) and the secondary status half-word (0x1E) always read 0x00A0, which is 66 MHz capable (bit 5) plus fast back-to-back capable (bit 7). Writes to them have no effect.
- R7: Byte 0x0E reads {MULTI_FUNC, 7'h01}, marking a bridge header. With the default MULTI_FUNC=0 the dword at 0x0C reads 0x00010000.
- R8: The low nibbles of the I/O base and limit bytes read 1 (32-bit I/O, IO_32BIT=1). The low nibbles of the prefetchable base and limit read 1 (64-bit, PREF_64BIT=1). The low nibbles of the memory base and limit read 0. Writes do not change any of these nibbles.
- R9: A write changes only the bytes whose enable is set. Command keeps bits 2:0 writable and its other bits read 0. Bridge control (0x3E) keeps bits 6:0 writable and its other bits read 0. Dwords outside the bridge register set read 0 and ignore writes.
- R10: The window outputs are formed as follows:
  - `io_base_o` = {I/O base upper16 (0x30), base[7:4], 12'h000};
  - `io_limit_o` = {I/O limit upper16 (0x32), limit[7:4], 12'hFFF};
  - the memory windows are {field[15:4], 20 zero or one bits};
  - the prefetchable windows carry the upper dwords above the same pattern;
  - `io_enable_o` and `mem_enable_o` are command bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| closed_on_reset | input | 1 | During reset, selects closed windows (1) or zeroed windows (0) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Dword index of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| rd_addr | input | ADDR_W | Dword index to read |
| rd_data | output | 32 | Combinational read data |
| remap_pulse_o | output | 1 | One-cycle window remap request |
| sec_bus_reset_o | output | 1 | One-cycle secondary bus reset request |
| io_enable_o | output | 1 | Command I/O space enable |
| mem_enable_o | output | 1 | Command memory space enable |
| io_base_o | output | 32 | Expanded I/O window base |
| io_limit_o | output | 32 | Expanded I/O window limit |
| mem_base_o | output | 32 | Expanded memory window base |
| mem_limit_o | output | 32 | Expanded memory window limit |
| pref_base_o | output | 64 | Expanded prefetchable window base |
| pref_limit_o | output | 64 | Expanded prefetchable window limit |

## Verification
The remap decode is tried with directed single-lane writes that sit just inside and just outside each trigger range, such as lane 1 versus lane 2 of dword 0x1C and byte 0x33 versus dword 0x34. These show whether the range edges are decoded per byte lane or per dword. The bus-reset pulse is driven through a set, rewrite, clear and set-again sequence, plus a set with lane 2 disabled, which separates edge detection from level detection. Random dword, data and byte-enable patterns are then compared against a bench model, so any byte-merge or read-only-mask mistake shows up in readback. Both reset modes are checked through the expanded window outputs.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
   localparam int HDR_DWORDS = 16;
   localparam int DW_CMD     = 1;
   localparam int DW_HDR     = 3;
   localparam int DW_BUS     = 6;
   localparam int DW_IO      = 7;
   localparam int DW_MEM     = 8;
   localparam int DW_PREF    = 9;
   localparam int DW_PBU     = 10;
   localparam int DW_PLU     = 11;
   localparam int DW_IOU     = 12;
   localparam int DW_BRCTL   = 15;
   localparam int SBR_BIT    = 6;
   localparam logic [15:0] STATUS_CAPS = 16'h00A0;
   localparam logic [6:0]  HDR_BRIDGE  = 7'h01;

   function automatic logic [31:0] merge_bytes(input logic [31:0] cur,
                                               input logic [31:0] wdat,
                                               input logic [3:0]  be);
      logic [31:0] r;
      for (int i = 0; i < 4; i++)
         r[i*8 +: 8] = be[i] ? wdat[i*8 +: 8] : cur[i*8 +: 8];
      return r;
   endfunction
endpackage

// File: rtl/bcfg_wr_decode.sv
module bcfg_wr_decode #(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [3:0]        wr_be,
   output logic              remap_hit
);
   localparam int BA_W = ADDR_W + 2;
   logic [3:0] lane_hit;

   for (genvar i = 0; i < 4; i++) begin : g_lane
      logic [BA_W-1:0] ba;
      int              bi;
      assign ba = {wr_addr, 2'(i)};
      assign bi = int'(ba);
      assign lane_hit[i] = wr_be[i] &&
                           (bi == 4 || bi == 5 || bi == 28 || bi == 29 ||
                            (bi >= 32 && bi <= 51));
   end

   assign remap_hit = |lane_hit;
endmodule

// File: rtl/bcfg_events.sv
module bcfg_events (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic remap_hit,
   input  logic brctl_wr,
   input  logic sbr_new,
   input  logic sbr_old,
   output logic remap_pulse,
   output logic sbr_pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remap_pulse <= 1'b0;
         sbr_pulse   <= 1'b0;
      end else begin
         remap_pulse <= wr_en && remap_hit;
         sbr_pulse   <= brctl_wr && sbr_new && !sbr_old;
      end
   end

   assert_remap_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && remap_hit) |=> remap_pulse);
   assert_sbr_one_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sbr_pulse |=> !sbr_pulse);
   assert_sbr_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sbr_pulse |-> $past(brctl_wr));
endmodule

// File: rtl/bcfg_regs.sv
module bcfg_regs
   import bcfg_pkg::*;
#(
   parameter int          ADDR_W     = 4,
   parameter bit          IO_32BIT   = 1'b1,
   parameter bit          PREF_64BIT = 1'b1,
   parameter bit          MULTI_FUNC = 1'b0,
   parameter logic [15:0] CMD_MASK   = 16'h0007,
   parameter logic [15:0] BRCTL_MASK = 16'h007F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              closed_on_reset,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [3:0]        wr_be,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              brctl_wr,
   output logic              sbr_state,
   output logic [15:0]       cmd_o,
   output logic [31:0]       io_base_o,
   output logic [31:0]       io_limit_o,
   output logic [31:0]       mem_base_o,
   output logic [31:0]       mem_limit_o,
   output logic [63:0]       pref_base_o,
   output logic [63:0]       pref_limit_o
);
   localparam logic [3:0] IO_TYPE   = IO_32BIT   ? 4'h1 : 4'h0;
   localparam logic [3:0] PREF_TYPE = PREF_64BIT ? 4'h1 : 4'h0;
   localparam logic [7:0] HDR_BYTE  = {MULTI_FUNC, HDR_BRIDGE};

   logic [15:0] cmd_q, brctl_q;
   logic [31:0] bus_q;
   logic [3:0]  iob_q, iol_q;
   logic [11:0] memb_q, meml_q, prefb_q, prefl_q;
   logic [31:0] pbu_q, plu_q;
   logic [15:0] iobu_q, iolu_q;

   logic [31:0] view [HDR_DWORDS];
   logic        wr_in, rd_in, wr_ok;
   logic [3:0]  wr_idx, rd_idx;
   logic [31:0] nxt;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover the 16-dword header");
   end
   if (!BRCTL_MASK[SBR_BIT]) begin : g_bad_brctl
      $error("BRCTL_MASK must keep the bus reset bit writable");
   end

   if (ADDR_W > 4) begin : g_range
      assign wr_in = ~|wr_addr[ADDR_W-1:4];
      assign rd_in = ~|rd_addr[ADDR_W-1:4];
   end else begin : g_norange
      assign wr_in = 1'b1;
      assign rd_in = 1'b1;
   end
   assign wr_idx = wr_addr[3:0];
   assign rd_idx = rd_addr[3:0];

   always_comb begin
      for (int i = 0; i < HDR_DWORDS; i++) view[i] = '0;
      view[DW_CMD]   = {STATUS_CAPS, cmd_q};
      view[DW_HDR]   = {8'h00, HDR_BYTE, 16'h0000};
      view[DW_BUS]   = bus_q;
      view[DW_IO]    = {STATUS_CAPS, iol_q, IO_TYPE, iob_q, IO_TYPE};
      view[DW_MEM]   = {meml_q, 4'h0, memb_q, 4'h0};
      view[DW_PREF]  = {prefl_q, PREF_TYPE, prefb_q, PREF_TYPE};
      view[DW_PBU]   = pbu_q;
      view[DW_PLU]   = plu_q;
      view[DW_IOU]   = {iolu_q, iobu_q};
      view[DW_BRCTL] = {brctl_q, 16'h0000};
   end

   assign rd_data = rd_in ? view[rd_idx] : 32'h0;
   assign wr_ok   = wr_en && wr_in;
   assign nxt     = merge_bytes(view[wr_idx], wr_data, wr_be);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         bus_q   <= '0;
         brctl_q <= '0;
         iob_q   <= {4{closed_on_reset}};
         iol_q   <= '0;
         memb_q  <= {12{closed_on_reset}};
         meml_q  <= '0;
         prefb_q <= {12{closed_on_reset}};
         prefl_q <= '0;
      end else if (wr_ok) begin
         case (wr_idx)
            4'(DW_CMD):   cmd_q   <= nxt[15:0] & CMD_MASK;
            4'(DW_BUS):   bus_q   <= nxt;
            4'(DW_IO): begin
               iob_q <= nxt[7:4];
               iol_q <= nxt[15:12];
            end
            4'(DW_MEM): begin
               memb_q <= nxt[15:4];
               meml_q <= nxt[31:20];
            end
            4'(DW_PREF): begin
               prefb_q <= nxt[15:4];
               prefl_q <= nxt[31:20];
            end
            4'(DW_BRCTL): brctl_q <= nxt[31:16] & BRCTL_MASK;
            default: ;
         endcase
      end
   end

   if (PREF_64BIT) begin : g_pref_up
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pbu_q <= '0;
            plu_q <= '0;
         end else if (wr_ok && wr_idx == 4'(DW_PBU)) begin
            pbu_q <= nxt;
         end else if (wr_ok && wr_idx == 4'(DW_PLU)) begin
            plu_q <= nxt;
         end
      end
   end else begin : g_pref_32
      assign pbu_q = '0;
      assign plu_q = '0;
   end

   if (IO_32BIT) begin : g_io_up
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            iobu_q <= '0;
            iolu_q <= '0;
         end else if (wr_ok && wr_idx == 4'(DW_IOU)) begin
            iobu_q <= nxt[15:0];
            iolu_q <= nxt[31:16];
         end
      end
   end else begin : g_io_16
      assign iobu_q = '0;
      assign iolu_q = '0;
   end

   assign brctl_wr     = wr_ok && wr_idx == 4'(DW_BRCTL) && wr_be[2];
   assign sbr_state    = brctl_q[SBR_BIT];
   assign cmd_o        = cmd_q;
   assign io_base_o    = {iobu_q, iob_q, 12'h000};
   assign io_limit_o   = {iolu_q, iol_q, 12'hFFF};
   assign mem_base_o   = {memb_q, 20'h00000};
   assign mem_limit_o  = {meml_q, 20'hFFFFF};
   assign pref_base_o  = {pbu_q, prefb_q, 20'h00000};
   assign pref_limit_o = {plu_q, prefl_q, 20'hFFFFF};

   assert_bus_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(DW_BUS)) |=> $stable(bus_q));
   assert_closed_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n) && $past(closed_on_reset)) |->
         (iob_q == 4'hF && iol_q == 4'h0 && memb_q == 12'hFFF && meml_q == 12'h000));
endmodule

// File: rtl/bridge_cfg_ctrl.sv
module bridge_cfg_ctrl #(
   parameter int          ADDR_W     = 4,
   parameter bit          IO_32BIT   = 1'b1,
   parameter bit          PREF_64BIT = 1'b1,
   parameter bit          MULTI_FUNC = 1'b0,
   parameter logic [15:0] CMD_MASK   = 16'h0007,
   parameter logic [15:0] BRCTL_MASK = 16'h007F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              closed_on_reset,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [3:0]        wr_be,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              remap_pulse_o,
   output logic              sec_bus_reset_o,
   output logic              io_enable_o,
   output logic              mem_enable_o,
   output logic [31:0]       io_base_o,
   output logic [31:0]       io_limit_o,
   output logic [31:0]       mem_base_o,
   output logic [31:0]       mem_limit_o,
   output logic [63:0]       pref_base_o,
   output logic [63:0]       pref_limit_o
);
   logic        remap_hit, brctl_wr, sbr_state;
   logic [15:0] cmd;

   bcfg_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .wr_addr   (wr_addr),
      .wr_be     (wr_be),
      .remap_hit (remap_hit)
   );

   bcfg_regs #(
      .ADDR_W(ADDR_W), .IO_32BIT(IO_32BIT), .PREF_64BIT(PREF_64BIT),
      .MULTI_FUNC(MULTI_FUNC), .CMD_MASK(CMD_MASK), .BRCTL_MASK(BRCTL_MASK)
   ) u_regs (
      .clk             (clk),
      .rst_n           (rst_n),
      .closed_on_reset (closed_on_reset),
      .wr_en           (wr_en),
      .wr_addr         (wr_addr),
      .wr_data         (wr_data),
      .wr_be           (wr_be),
      .rd_addr         (rd_addr),
      .rd_data         (rd_data),
      .brctl_wr        (brctl_wr),
      .sbr_state       (sbr_state),
      .cmd_o           (cmd),
      .io_base_o       (io_base_o),
      .io_limit_o      (io_limit_o),
      .mem_base_o      (mem_base_o),
      .mem_limit_o     (mem_limit_o),
      .pref_base_o     (pref_base_o),
      .pref_limit_o    (pref_limit_o)
   );

   bcfg_events u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .remap_hit   (remap_hit),
      .brctl_wr    (brctl_wr),
      .sbr_new     (wr_data[16 + bcfg_pkg::SBR_BIT]),
      .sbr_old     (sbr_state),
      .remap_pulse (remap_pulse_o),
      .sbr_pulse   (sec_bus_reset_o)
   );

   assign io_enable_o  = cmd[0];
   assign mem_enable_o = cmd[1];

   assert_sbr_sets_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_bus_reset_o |-> sbr_state);
   assert_remap_one_per_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (remap_pulse_o && !$past(wr_en, 2)) |=> (!remap_pulse_o || $past(wr_en)));
endmodule

// File: tb/bridge_cfg_ctrl_test.sv
`timescale 1ns/1ps
module bridge_cfg_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        closed_on_reset = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_be = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        remap_pulse_o, sec_bus_reset_o, io_enable_o, mem_enable_o;
   logic [31:0] io_base_o, io_limit_o, mem_base_o, mem_limit_o;
   logic [63:0] pref_base_o, pref_limit_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // expected register state
   logic [15:0] m_cmd, m_brctl, m_iobu, m_iolu;
   logic [31:0] m_bus, m_pbu, m_plu;
   logic [3:0]  m_iob, m_iol;
   logic [11:0] m_memb, m_meml, m_prefb, m_prefl;

   always #2.5 clk = ~clk;

   bridge_cfg_ctrl uut (.*);

   function automatic logic [31:0] mg(input logic [31:0] o, input logic [31:0] d,
                                      input logic [3:0] be);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : o[i*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] exp_view(input int a);
      case (a)
         1:  return {16'h00A0, m_cmd};
         3:  return 32'h0001_0000;
         6:  return m_bus;
         7:  return {16'h00A0, m_iol, 4'h1, m_iob, 4'h1};
         8:  return {m_meml, 4'h0, m_memb, 4'h0};
         9:  return {m_prefl, 4'h1, m_prefb, 4'h1};
         10: return m_pbu;
         11: return m_plu;
         12: return {m_iolu, m_iobu};
         15: return {m_brctl, 16'h0000};
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit exp_remap(input int a, input logic [3:0] be);
      bit r = 1'b0;
      for (int i = 0; i < 4; i++) begin
         int b = a * 4 + i;
         if (be[i] && (b == 4 || b == 5 || b == 28 || b == 29 || (b >= 32 && b <= 51)))
            r = 1'b1;
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset(input bit closed);
      m_cmd = '0; m_brctl = '0; m_bus = '0; m_pbu = '0; m_plu = '0;
      m_iobu = '0; m_iolu = '0; m_iol = '0; m_meml = '0; m_prefl = '0;
      m_iob   = closed ? 4'hF : 4'h0;
      m_memb  = closed ? 12'hFFF : 12'h000;
      m_prefb = closed ? 12'hFFF : 12'h000;
   endtask

   task automatic do_reset(input bit closed);
      @(negedge clk);
      rst_n = 1'b0; closed_on_reset = closed; wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset(closed);
      @(negedge clk);
      chk("R1 no remap after reset", remap_pulse_o, 0);
      chk("R2 no bus reset after reset", sec_bus_reset_o, 0);
   endtask

   task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be);
      bit er, es;
      logic [31:0] nx;
      er = exp_remap(a, be);
      es = (a == 15) && be[2] && d[22] && !m_brctl[6];
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = d; wr_be = be;
      @(negedge clk);
      chk($sformatf("R1 remap dw%0d be%b", a, be), remap_pulse_o, er);
      chk($sformatf("R2 bus reset dw%0d be%b", a, be), sec_bus_reset_o, es);
      wr_en = 1'b0;
      nx = mg(exp_view(a), d, be);
      case (a)
         1:  m_cmd = nx[15:0] & 16'h0007;
         6:  m_bus = nx;
         7:  begin m_iob = nx[7:4]; m_iol = nx[15:12]; end
         8:  begin m_memb = nx[15:4]; m_meml = nx[31:20]; end
         9:  begin m_prefb = nx[15:4]; m_prefl = nx[31:20]; end
         10: m_pbu = nx;
         11: m_plu = nx;
         12: begin m_iobu = nx[15:0]; m_iolu = nx[31:16]; end
         15: m_brctl = nx[31:16] & 16'h007F;
         default: ;
      endcase
      rd_addr = 4'(a);
      #1;
      chk($sformatf("R9 readback dw%0d", a), rd_data, exp_view(a));
   endtask

   task automatic check_windows(input string tag);
      chk({tag, " R10 io base"}, io_base_o, {m_iobu, m_iob, 12'h000});
      chk({tag, " R10 io limit"}, io_limit_o, {m_iolu, m_iol, 12'hFFF});
      chk({tag, " R10 mem base"}, mem_base_o, {m_memb, 20'h0});
      chk({tag, " R10 mem limit"}, mem_limit_o, {m_meml, 20'hFFFFF});
      chk({tag, " R10 pref base"}, pref_base_o, {m_pbu, m_prefb, 20'h0});
      chk({tag, " R10 pref limit"}, pref_limit_o, {m_plu, m_prefl, 20'hFFFFF});
      chk({tag, " R10 enables"}, {io_enable_o, mem_enable_o}, {m_cmd[0], m_cmd[1]});
   endtask

   task automatic read_all(input string tag);
      for (int a = 0; a < 16; a++) begin
         rd_addr = 4'(a);
         #1;
         chk($sformatf("%s dw%0d", tag, a), rd_data, exp_view(a));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset(1'b0);
      // R3 R4 reset values, R6 status, R7 header, R8 type nibbles
      rd_addr = 4'd6; #1; chk("R3 bus numbers after reset", rd_data, 32'h0);
      rd_addr = 4'd7; #1; chk("R4 R6 R8 io dword after reset", rd_data, 32'h00A0_0101);
      rd_addr = 4'd8; #1; chk("R4 mem dword after reset", rd_data, 32'h0);
      rd_addr = 4'd9; #1; chk("R4 R8 pref dword after reset", rd_data, 32'h0001_0001);
      rd_addr = 4'd15; #1; chk("R4 bridge control after reset", rd_data, 32'h0);
      rd_addr = 4'd1; #1; chk("R6 primary status", rd_data, 32'h00A0_0000);
      rd_addr = 4'd3; #1; chk("R7 header type", rd_data, 32'h0001_0000);
      read_all("R4 reset image");
      check_windows("R4 reset");

      // R1 range edges
      do_write(0, 32'hFFFF_FFFF, 4'hF);
      do_write(1, 32'hFFFF_0000, 4'b1100);
      do_write(1, 32'h0000_0003, 4'b0001);
      do_write(7, 32'hFFFF_FFFF, 4'b0100);
      do_write(7, 32'h0000_A000, 4'b0010);
      do_write(7, 32'h0000_0050, 4'b0001);
      do_write(6, 32'h0040_0201, 4'hF);
      do_write(13, 32'h1234_5678, 4'hF);
      do_write(12, 32'hAB00_0000, 4'b1000);
      do_write(8, 32'h1230_0450, 4'b0001);
      do_write(11, 32'h0000_0001, 4'b0001);
      do_write(14, 32'hFFFF_FFFF, 4'hF);
      // R8: type nibbles survive all-ones writes
      do_write(9, 32'hFFFF_FFFF, 4'hF);
      do_write(9, 32'h0000_0000, 4'hF);

      // R2 edge sequence
      do_write(15, 32'h0040_0000, 4'b0100);
      do_write(15, 32'h0040_0000, 4'b0100);
      do_write(15, 32'h0000_0000, 4'b0100);
      do_write(15, 32'h0040_0000, 4'b1011);
      do_write(15, 32'h0041_0000, 4'b1100);
      check_windows("R10 directed");

      // random mix
      for (int k = 0; k < 800; k++) begin
         int a;
         int pick = $urandom_range(0, 3);
         a = (pick == 0) ? 15 : (pick == 1) ? $urandom_range(6, 12) : $urandom_range(0, 15);
         do_write(a, $urandom, 4'($urandom_range(0, 15)));
      end
      read_all("R9 random image");
      check_windows("R10 random");

      // R5 closed windows
      do_reset(1'b1);
      chk("R5 io base", io_base_o, 64'h0000_F000);
      chk("R5 io limit", io_limit_o, 64'h0000_0FFF);
      chk("R5 mem base", mem_base_o, 64'hFFF0_0000);
      chk("R5 mem limit", mem_limit_o, 64'h000F_FFFF);
      chk("R5 pref base", pref_base_o, 64'h0000_0000_FFF0_0000);
      chk("R5 pref limit", pref_limit_o, 64'h0000_0000_000F_FFFF);
      read_all("R5 closed image");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule